// File: doc/BRIEF.md
# Adaptive Dead-Time Gate-Drive Sequencer

This block turns a digitized PWM command into two gate enables for a synchronous buck power stage. One enable drives the high-side switch and the other drives the low-side switch. Break-before-make is closed-loop. The block removes the conducting gate first and waits until a comparator reports that this gate has discharged below its threshold. It then waits a programmable number of clock cycles before it enables the opposite gate. The threshold flag is watched for the whole of that wait.

The PWM input arrives as a three-level code: low, high, or inside a mid-level shutdown window. If the code stays in the window long enough, both gates are parked low and a status flag is raised. With forced-continuous mode deselected, the block performs diode emulation: once the low-side gate has been on for a minimum time, an inductor zero-crossing flag turns it off. A supply-good flag overrides everything else.

All timing quantities are counted in clock cycles and set by parameters: the holdoff, the minimum low-side on-time and the base dead-time. The extra dead-time is a register input that saturates at a parameter value.

Top module: `gate_seq`

## Requirements
- R1: Whenever `pwm_code` is 2'b01 (high) at a clock edge, `ls_en` is low after that edge. `hs_en` rises only at an edge where `ls_below` was high and `ls_en` was already low.
- R2: When the command is low (`pwm_code` 2'b00), `hs_en` is low after that edge. `ls_en` rises only at an edge where `hs_below` was high and `hs_en` was already low.
- R3: The opposite gate turns on after the threshold flag has been seen high and the dead-time has run. The dead-time is `BASE_DT_CYC + min(extra_dt, EXTRA_MAX)` cycles, so the gate rises that many edges plus one after the flag is first presented. If the flag drops during the dead-time, the wait starts over.
- R4: If the command reverses before the pending gate is enabled, that gate is never enabled. The block sequences toward the new command instead, still honouring R1/R2.
- R5: Codes 2'b10 and 2'b11 lie inside the shutdown window. Once the code has been sampled in the window on `HOLDOFF_CYC` consecutive edges, `shutdown` is high and both enables are low from that edge on.
- R6: `shutdown` clears at the first edge that samples a code outside the window. A window visit shorter than the holdoff changes nothing: the last high/low command is kept. After shutdown, the normal R1/R2 sequencing resumes.
- R7: With `force_ccm` low and `zero_cross` high, the low-side gate turns off after exactly `MIN_LS_ON_CYC` cycles on. It stays off until the command goes high or `force_ccm` rises.
- R8: With `force_ccm` high, `zero_cross` has no effect. Changing `force_ccm` acts at the next edge, without waiting for a PWM edge. Raising it restarts the low-side sequence; lowering it allows an immediate cutoff once the minimum on-time is met.
- R9: While `pwr_good` is low, both enables are low within the same cycle. After it returns, sequencing restarts from both-off.
- R10: During and right after reset both enables and `shutdown` are low, and the two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good flag; low forces both gates off |
| pwm_code | input | 2 | 00 low, 01 high, 1x shutdown window |
| hs_below | input | 1 | High-side gate-to-phase voltage below threshold |
| ls_below | input | 1 | Low-side gate voltage below threshold |
| zero_cross | input | 1 | Inductor current has reached zero |
| force_ccm | input | 1 | High forces continuous conduction |
| extra_dt | input | EXTRA_W | Extra dead-time in cycles, saturating at EXTRA_MAX |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| shutdown | output | 1 | Shutdown window holdoff expired |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume the threshold flags are real gate feedback, so a flag reports "below" only when the gate could actually be discharged. The bench changes every input only on falling edges. In its randomized phase it derives each threshold flag from the enables it last observed: the flag is forced low while that gate is enabled and is random otherwise. The PWM code is held in runs, so some window visits reach the holdoff and others fall short.

// File: rtl/gate_seq.sv
module gate_seq #(
  parameter int HOLDOFF_CYC   = 7,
  parameter int MIN_LS_ON_CYC = 40,
  parameter int BASE_DT_CYC   = 1,
  parameter int EXTRA_W       = 4,
  parameter int EXTRA_MAX     = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic [1:0]         pwm_code,
  input  logic               hs_below,
  input  logic               ls_below,
  input  logic               zero_cross,
  input  logic               force_ccm,
  input  logic [EXTRA_W-1:0] extra_dt,
  output logic               hs_en,
  output logic               ls_en,
  output logic               shutdown
);

  localparam int HW  = $clog2(HOLDOFF_CYC + 1);
  localparam int OW  = $clog2(MIN_LS_ON_CYC + 1);
  localparam int DTW = $clog2(BASE_DT_CYC + EXTRA_MAX + 1);
  localparam logic [HW-1:0]      HOLD_LAST = HW'(HOLDOFF_CYC - 1);
  localparam logic [HW-1:0]      HOLD_SAT  = HW'(HOLDOFF_CYC);
  localparam logic [OW-1:0]      ON_LAST   = OW'(MIN_LS_ON_CYC - 1);
  localparam logic [OW-1:0]      ON_SAT    = OW'(MIN_LS_ON_CYC);
  localparam logic [EXTRA_W-1:0] XMAX      = EXTRA_W'(EXTRA_MAX);

  typedef enum logic [2:0] {
    ST_OFF, ST_TO_HI_WAIT, ST_TO_HI_DT, ST_HI_ON,
    ST_TO_LO_WAIT, ST_TO_LO_DT, ST_LO_ON, ST_DCM_IDLE
  } st_t;

  st_t              st, nxt;
  logic             cmd_q, cmd, in_window, shut_nxt, dcm_cut;
  logic [HW-1:0]    mid_cnt;
  logic [OW-1:0]    on_cnt;
  logic [DTW-1:0]   dt_cnt, dt_load;
  logic [EXTRA_W-1:0] extra_eff;

  assign in_window = pwm_code[1];
  assign cmd       = in_window ? cmd_q : pwm_code[0];
  assign shut_nxt  = in_window && (mid_cnt >= HOLD_LAST);
  assign extra_eff = (extra_dt > XMAX) ? XMAX : extra_dt;
  assign dt_load   = DTW'(BASE_DT_CYC) + DTW'(extra_eff) - DTW'(1);
  assign dcm_cut   = !force_ccm && zero_cross && (on_cnt >= ON_LAST);

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:        nxt = cmd ? ST_TO_HI_WAIT : ST_TO_LO_WAIT;
      ST_TO_HI_WAIT: if (!cmd) nxt = ST_TO_LO_WAIT;
                     else if (ls_below) nxt = ST_TO_HI_DT;
      ST_TO_HI_DT:   if (!cmd) nxt = ST_TO_LO_WAIT;
                     else if (!ls_below) nxt = ST_TO_HI_WAIT;
                     else if (dt_cnt == '0) nxt = ST_HI_ON;
      ST_HI_ON:      if (!cmd) nxt = ST_TO_LO_WAIT;
      ST_TO_LO_WAIT: if (cmd) nxt = ST_TO_HI_WAIT;
                     else if (hs_below) nxt = ST_TO_LO_DT;
      ST_TO_LO_DT:   if (cmd) nxt = ST_TO_HI_WAIT;
                     else if (!hs_below) nxt = ST_TO_LO_WAIT;
                     else if (dt_cnt == '0) nxt = ST_LO_ON;
      ST_LO_ON:      if (cmd) nxt = ST_TO_HI_WAIT;
                     else if (dcm_cut) nxt = ST_DCM_IDLE;
      ST_DCM_IDLE:   if (cmd) nxt = ST_TO_HI_WAIT;
                     else if (force_ccm) nxt = ST_TO_LO_WAIT;
      default:       nxt = ST_OFF;
    endcase
    if (!pwr_good || shut_nxt) nxt = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      cmd_q    <= 1'b0;
      mid_cnt  <= '0;
      shutdown <= 1'b0;
      dt_cnt   <= '0;
      on_cnt   <= '0;
    end else begin
      st       <= nxt;
      cmd_q    <= cmd;
      shutdown <= shut_nxt;
      if (!in_window)            mid_cnt <= '0;
      else if (mid_cnt != HOLD_SAT) mid_cnt <= mid_cnt + HW'(1);
      if (nxt != st)             dt_cnt <= dt_load;
      else if (dt_cnt != '0)     dt_cnt <= dt_cnt - DTW'(1);
      if (nxt != st)             on_cnt <= '0;
      else if (on_cnt != ON_SAT) on_cnt <= on_cnt + OW'(1);
    end
  end

  assign hs_en = pwr_good && (st == ST_HI_ON);
  assign ls_en = pwr_good && (st == ST_LO_ON);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R1
  hs_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(ls_below) && !$past(ls_en)));

  // R1
  hi_cmd_drops_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_code == 2'b01) |=> !ls_en);

  // R2
  ls_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> ($past(hs_below) && !$past(hs_en)));

  // R5
  shut_gates_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!hs_en && !ls_en));

  // R6
  shut_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_code[1] |=> !shutdown);

endmodule

// File: tb/tb_gate_seq.sv
module tb_gate_seq;
  localparam int HOLD = 7, MINON = 40, BASE = 1, EW = 4, EMAX = 9;
  localparam logic [1:0] C_LO = 2'b00, C_HI = 2'b01, C_MID = 2'b10;

  logic clk = 0, rst_n = 0, pwr_good = 1, hs_below = 1, ls_below = 1;
  logic zero_cross = 0, force_ccm = 1;
  logic [1:0] pwm_code = C_LO;
  logic [EW-1:0] extra_dt = '0;
  logic hs_en, ls_en, shutdown;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gate_seq #(.HOLDOFF_CYC(HOLD), .MIN_LS_ON_CYC(MINON), .BASE_DT_CYC(BASE),
             .EXTRA_W(EW), .EXTRA_MAX(EMAX)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pwm_code(pwm_code),
    .hs_below(hs_below), .ls_below(ls_below), .zero_cross(zero_cross),
    .force_ccm(force_ccm), .extra_dt(extra_dt),
    .hs_en(hs_en), .ls_en(ls_en), .shutdown(shutdown));

  function automatic int dtc(int e);
    return BASE + ((e > EMAX) ? EMAX : e);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic prev_hs, prev_ls, last_hsb, last_lsb;
    void'($urandom(32'd4711));
    tk(2);
    chk("R10 reset hs", hs_en, 0);
    chk("R10 reset ls", ls_en, 0);
    chk("R10 reset shutdown", shutdown, 0);
    rst_n = 1;
    tk(2); chk("R2 ls waits dead-time", ls_en, 0);
    tk(1); chk("R2 ls on after start", ls_en, 1);
    ls_below = 0;

    // R1 rising command
    pwm_code = C_HI;
    tk(1); chk("R1 ls dropped", ls_en, 0); chk("R1 hs not yet", hs_en, 0);
    tk(3); chk("R1 hs waits ls feedback", hs_en, 0);
    ls_below = 1;
    tk(1); chk("R1 hs in dead-time", hs_en, 0);
    tk(1); chk("R1 hs on", hs_en, 1);
    hs_below = 0;

    // R2/R3 falling with extra dead-time
    extra_dt = 3; pwm_code = C_LO;
    tk(1); chk("R2 hs dropped", hs_en, 0);
    tk(2); chk("R2 ls waits hs feedback", ls_en, 0);
    hs_below = 1;
    tk(dtc(3)); chk("R3 ls still in dead-time", ls_en, 0);
    tk(1); chk("R3 ls on after dead-time", ls_en, 1);
    ls_below = 0;

    // R3 saturation
    extra_dt = 15; pwm_code = C_HI;
    tk(1); ls_below = 1;
    tk(dtc(15)); chk("R3 saturated dead-time hs off", hs_en, 0);
    tk(1); chk("R3 saturated dead-time hs on", hs_en, 1);
    hs_below = 0;

    // R3 feedback drop restarts wait
    extra_dt = 3; pwm_code = C_LO;
    tk(1); hs_below = 1;
    tk(2); hs_below = 0;
    tk(8); chk("R3 feedback drop holds ls off", ls_en, 0);
    hs_below = 1;
    tk(dtc(3)); chk("R3 restarted dead-time", ls_en, 0);
    tk(1); chk("R3 ls on after restart", ls_en, 1);
    ls_below = 0;

    // R4 reversal while waiting
    extra_dt = 0; pwm_code = C_HI;
    tk(3); chk("R4 hs waits", hs_en, 0);
    pwm_code = C_LO;
    tk(dtc(0) + 1); chk("R4 hs never on", hs_en, 0); chk("R4 ls not yet", ls_en, 0);
    tk(1); chk("R4 ls back on", ls_en, 1);

    // R5/R6 shutdown window
    pwm_code = C_MID;
    tk(HOLD - 1); chk("R6 short window keeps ls", ls_en, 1); chk("R5 no shutdown yet", shutdown, 0);
    tk(1); chk("R5 shutdown set", shutdown, 1); chk("R5 ls off", ls_en, 0);
    ls_below = 1;
    tk(5); chk("R5 hs held off", hs_en, 0); chk("R5 shutdown held", shutdown, 1);
    pwm_code = C_HI;
    tk(1); chk("R6 shutdown cleared", shutdown, 0);
    tk(1); chk("R6 hs in dead-time", hs_en, 0);
    tk(1); chk("R6 hs on after exit", hs_en, 1);
    hs_below = 0;
    pwm_code = C_MID;
    tk(3); pwm_code = C_HI;
    tk(1); chk("R6 glitch no shutdown", shutdown, 0); chk("R6 glitch keeps hs", hs_en, 1);
    pwm_code = 2'b11;
    tk(HOLD); chk("R5 code 11 shuts down", shutdown, 1); chk("R5 hs off", hs_en, 0);
    hs_below = 1; pwm_code = C_LO;
    tk(2); chk("R6 ls sequencing", ls_en, 0);
    tk(1); chk("R6 ls on", ls_en, 1);
    ls_below = 0;

    // R7 diode emulation
    pwm_code = C_HI; tk(1); ls_below = 1; tk(2); hs_below = 0;
    force_ccm = 0; zero_cross = 1; pwm_code = C_LO;
    tk(1); hs_below = 1;
    tk(2); chk("R7 ls on in dcm", ls_en, 1);
    ls_below = 0;
    tk(MINON - 1); chk("R7 min on-time", ls_en, 1);
    tk(1); chk("R7 zero cross cut", ls_en, 0);
    ls_below = 1;
    tk(5); chk("R7 stays cut", ls_en, 0);

    // R8 mode select
    force_ccm = 1;
    tk(2); chk("R8 ccm restart sequencing", ls_en, 0);
    tk(1); chk("R8 ccm ls on", ls_en, 1);
    ls_below = 0;
    tk(60); chk("R8 zero cross ignored", ls_en, 1);
    force_ccm = 0;
    tk(1); chk("R8 immediate cut", ls_en, 0);
    ls_below = 1; zero_cross = 0; force_ccm = 1;
    tk(3); ls_below = 0;

    // R9 supply
    pwm_code = C_HI; tk(1); ls_below = 1; tk(2);
    chk("R9 hs on before", hs_en, 1);
    hs_below = 0;
    pwr_good = 0; #1;
    chk("R9 hs off same cycle", hs_en, 0);
    hs_below = 1;
    tk(3); chk("R9 hs held", hs_en, 0); chk("R9 ls held", ls_en, 0);
    pwr_good = 1;
    tk(2); chk("R9 restart hs off", hs_en, 0);
    tk(1); chk("R9 restart hs on", hs_en, 1);

    // randomized phase with invariant checks
    prev_hs = hs_en; prev_ls = ls_en;
    last_hsb = hs_below; last_lsb = ls_below;
    for (int i = 0; i < 4000; i++) begin
      tk(1);
      chk("R10 no overlap", hs_en && ls_en, 0);
      if (shutdown) chk("R5 gates low in shutdown", hs_en || ls_en, 0);
      if (!pwr_good) chk("R9 gates low without supply", hs_en || ls_en, 0);
      if (hs_en && !prev_hs) chk("R1 hs rise gated", last_lsb && !prev_ls, 1);
      if (ls_en && !prev_ls) chk("R2 ls rise gated", last_hsb && !prev_hs, 1);
      prev_hs = hs_en; prev_ls = ls_en;
      if ($urandom % 10 == 0) pwm_code = 2'($urandom % 4);
      if ($urandom % 50 == 0) force_ccm = ~force_ccm;
      if ($urandom % 40 == 0) extra_dt = EW'($urandom);
      pwr_good   = ($urandom % 150) != 0;
      zero_cross = ($urandom % 8) == 0;
      hs_below   = hs_en ? 1'b0 : (($urandom % 4) != 0);
      ls_below   = ls_en ? 1'b0 : (($urandom % 4) != 0);
      last_hsb = hs_below; last_lsb = ls_below;
    end
    finish_run();
  end
endmodule